// File: doc/BRIEF.md
# Wishbone Single-Master Address Decoder

This block sits between one Wishbone master and a fixed set of slave ports. It selects a slave by comparing a small number of the master's upper address bits with a base address set for each slave. Only the selected slave sees cycle and strobe. That slave's read data and acknowledge are steered back to the master in the same cycle. Write enable, byte selects and write data go to every slave unchanged.

Each slave has its own data width (8, 16 or 32 bits), its own addressing mode (byte or word) and its own address width. From these the block builds the address the slave receives. In word mode the master address is shifted right so that consecutive slave addresses step by one data word. In byte mode it is passed through as it is. The result is then cut to the slave's address width. A request that hits no slave is answered with a one-clock error pulse, so the master never waits forever.

Top module: `wb_slave_decoder`

## Requirements
- R1: Slave i is matched when master address bits [AW-1:AW-DEC_W] equal the top DEC_W bits of that slave's base address. With the default settings (AW=24, DEC_W=3), the base values 0x000000, 0x200000, 0x200000 and 0xE00000 match tags 000, 001, 001 and 111.
- R2: The cycle and strobe outputs of a slave are high only when that slave is selected and the master's cycle and strobe inputs are both high.
- R3: When several slaves match, only the lowest-indexed one is selected. At most one slave is selected at any time.
- R4: Write enable, byte selects and write data reach every slave unchanged, whether or not that slave is selected.
- R5: The master's read data and acknowledge come from the selected slave in the same cycle. The acknowledges of unselected slaves are ignored. Read data is zero when no slave is selected.
- R6: For a byte-mode slave, its address equals the master address without any shift.
- R7: For a word-mode slave, the master address is shifted right by 2 for a 32-bit slave, by 1 for a 16-bit slave, and by 0 for an 8-bit slave. Width codes: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. Mode bit: 1 = word, 0 = byte.
- R8: Each slave's address output drives zero on all bits at or above its own address width.
- R9: If the master's cycle and strobe are high at a clock edge and no slave matches, the error output is high for the following clock. It then goes low for at least one clock. No error is raised when the master is idle or a slave matches.
- R10: While reset is held, no error is signalled, and until the synchronised reset is released no error can be raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| m_cyc_i | input | 1 | Master cycle |
| m_stb_i | input | 1 | Master strobe |
| m_we_i | input | 1 | Master write enable |
| m_sel_i | input | DW/8 | Master byte selects |
| m_adr_i | input | AW | Master byte address |
| m_dat_i | input | DW | Master write data |
| m_dat_o | output | DW | Read data to master |
| m_ack_o | output | 1 | Acknowledge to master |
| m_err_o | output | 1 | Error for an unmatched request |
| s_cyc_o | output | NS | Per-slave cycle |
| s_stb_o | output | NS | Per-slave strobe |
| s_we_o | output | 1 | Shared write enable |
| s_sel_o | output | DW/8 | Shared byte selects |
| s_adr_o | output | NS*AW | Per-slave remapped address, slave i at [i*AW +: AW] |
| s_dat_o | output | DW | Shared write data |
| s_dat_i | input | NS*DW | Per-slave read data, slave i at [i*DW +: DW] |
| s_ack_i | input | NS | Per-slave acknowledge |

## Verification
The only internal state is the error flag, together with the reset synchroniser that controls it. A flag stuck high, or one that fails to clear, shows up one clock after an unmatched request as a missing, repeated or spurious error pulse. Select, address remapping and return-path faults are combinational. They appear at the ports in the same cycle as the request that exposes them: as a wrong or doubled slave cycle, a mis-shifted or unmasked slave address, or read data taken from the wrong slave. The bench compares every output against a behavioural model on each clock. It drives the overlapping base region, the unmapped tags, held strobes on a miss, and a strobe without a cycle.

// File: rtl/wbdec_pkg.sv
package wbdec_pkg;

  // Data width codes used in the per-slave width parameter.
  typedef enum logic [1:0] {
    WB_W8  = 2'd0,
    WB_W16 = 2'd1,
    WB_W32 = 2'd2
  } wb_width_e;

  // Right shift applied to the master address for one slave.
  function automatic int unsigned lane_shift(input logic [1:0] code, input logic word_mode);
    if (!word_mode) return 0;
    case (code)
      WB_W16:  return 1;
      WB_W32:  return 2;
      default: return 0;
    endcase
  endfunction

  // Mask keeping the lowest `bits` bits of an aw-bit address.
  function automatic logic [63:0] low_mask(input int unsigned bits, input int unsigned aw);
    logic [63:0] m;
    m = '0;
    for (int unsigned k = 0; k < 64; k++) begin
      if (k < bits && k < aw) m[k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/wbdec_match.sv
module wbdec_match #(
  parameter int unsigned AW    = 24,
  parameter int unsigned DEC_W = 3,
  parameter int unsigned NS    = 4,
  parameter logic [NS*AW-1:0] BASES = '0
) (
  input  logic [AW-1:0] adr_i,
  output logic [NS-1:0] hit_o
);

  logic [DEC_W-1:0] tag_in;
  assign tag_in = adr_i[AW-1 -: DEC_W];

  for (genvar i = 0; i < NS; i++) begin : g_cmp
    localparam logic [DEC_W-1:0] TAG = BASES[i*AW + AW - 1 -: DEC_W];
    assign hit_o[i] = (tag_in == TAG);
  end

endmodule

// File: rtl/wbdec_prio.sv
module wbdec_prio #(
  parameter int unsigned NS = 4
) (
  input  logic [NS-1:0] req_i,
  output logic [NS-1:0] grant_o
);

  // Lowest index wins.
  always_comb begin
    logic taken;
    taken   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NS; i++) begin
      if (req_i[i] && !taken) begin
        grant_o[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wbdec_adrmap.sv
module wbdec_adrmap #(
  parameter int unsigned AW = 24,
  parameter int unsigned NS = 4,
  parameter logic [NS*2-1:0] WIDTHS    = '0,
  parameter logic [NS-1:0]   WORD_MODE = '0,
  parameter logic [NS*8-1:0] SLV_AW    = '0
) (
  input  logic [AW-1:0]    adr_i,
  output logic [NS*AW-1:0] adr_o
);

  import wbdec_pkg::*;

  for (genvar i = 0; i < NS; i++) begin : g_map
    localparam int unsigned SH   = lane_shift(WIDTHS[i*2 +: 2], WORD_MODE[i]);
    localparam int unsigned SA   = int'(SLV_AW[i*8 +: 8]);
    localparam logic [63:0] M64  = low_mask(SA, AW);
    localparam logic [AW-1:0] MASK = M64[AW-1:0];

    logic [AW-1:0] shifted;
    assign shifted = adr_i >> SH;
    assign adr_o[i*AW +: AW] = shifted & MASK;
  end

endmodule

// File: rtl/wb_slave_decoder.sv
module wb_slave_decoder #(
  parameter int unsigned AW    = 24,
  parameter int unsigned DW    = 32,
  parameter int unsigned NS    = 4,
  parameter int unsigned DEC_W = 3,
  parameter logic [NS*AW-1:0] BASES     = {24'hE00000, 24'h200000, 24'h200000, 24'h000000},
  parameter logic [NS*2-1:0]  WIDTHS    = {2'd2, 2'd0, 2'd1, 2'd2},
  parameter logic [NS-1:0]    WORD_MODE = 4'b0111,
  parameter logic [NS*8-1:0]  SLV_AW    = {8'd16, 8'd8, 8'd10, 8'd12}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             m_cyc_i,
  input  logic             m_stb_i,
  input  logic             m_we_i,
  input  logic [DW/8-1:0]  m_sel_i,
  input  logic [AW-1:0]    m_adr_i,
  input  logic [DW-1:0]    m_dat_i,
  output logic [DW-1:0]    m_dat_o,
  output logic             m_ack_o,
  output logic             m_err_o,
  output logic [NS-1:0]    s_cyc_o,
  output logic [NS-1:0]    s_stb_o,
  output logic             s_we_o,
  output logic [DW/8-1:0]  s_sel_o,
  output logic [NS*AW-1:0] s_adr_o,
  output logic [DW-1:0]    s_dat_o,
  input  logic [NS*DW-1:0] s_dat_i,
  input  logic [NS-1:0]    s_ack_i
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // Decode and select.
  logic          active;
  logic [NS-1:0] hit;
  logic [NS-1:0] grant;
  logic [NS-1:0] sel;
  logic          any_sel;

  assign active = m_cyc_i & m_stb_i;

  wbdec_match #(.AW(AW), .DEC_W(DEC_W), .NS(NS), .BASES(BASES)) u_match (
    .adr_i (m_adr_i),
    .hit_o (hit)
  );

  wbdec_prio #(.NS(NS)) u_prio (
    .req_i   (hit),
    .grant_o (grant)
  );

  assign sel     = grant & {NS{active}};
  assign any_sel = |sel;
  assign s_cyc_o = sel;
  assign s_stb_o = sel;

  // Fan-out and address remap.
  assign s_we_o  = m_we_i;
  assign s_sel_o = m_sel_i;
  assign s_dat_o = m_dat_i;

  wbdec_adrmap #(
    .AW(AW), .NS(NS), .WIDTHS(WIDTHS), .WORD_MODE(WORD_MODE), .SLV_AW(SLV_AW)
  ) u_adrmap (
    .adr_i (m_adr_i),
    .adr_o (s_adr_o)
  );

  // Return path: and-or mux over a one-hot select.
  always_comb begin
    m_dat_o = '0;
    m_ack_o = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (sel[i]) begin
        m_dat_o = m_dat_o | s_dat_i[i*DW +: DW];
        m_ack_o = m_ack_o | s_ack_i[i];
      end
    end
  end

  // Error pulse for an unmatched request.
  logic err_q, err_d, err_en;

  always_comb begin
    err_en = err_q | (active & ~any_sel);
    err_d  = ~err_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)  err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign m_err_o = err_q;

  // Assertions
  AST_ONE_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_cyc_o)); // R3

  AST_SEL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|s_stb_o) |-> (m_cyc_i && m_stb_i)); // R2

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_err_o |=> !m_err_o); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_err_o |-> $past(m_cyc_i && m_stb_i && (s_cyc_o == '0))); // R9

  AST_ACK_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_ack_o |-> ((s_cyc_o & s_ack_i) != '0)); // R5

endmodule

// File: tb/wb_slave_decoder_bench.sv
`timescale 1ns/1ps
module wb_slave_decoder_bench;

  localparam int AW = 24, DW = 32, NS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            m_cyc, m_stb, m_we;
  logic [3:0]      m_sel;
  logic [AW-1:0]   m_adr;
  logic [DW-1:0]   m_dat;
  logic [DW-1:0]   m_dat_o;
  logic            m_ack_o, m_err_o;
  logic [NS-1:0]   s_cyc_o, s_stb_o;
  logic            s_we_o;
  logic [3:0]      s_sel_o;
  logic [NS*AW-1:0] s_adr_o;
  logic [DW-1:0]   s_dat_o;
  logic [NS*DW-1:0] s_dat_i;
  logic [NS-1:0]   s_ack_i;

  wb_slave_decoder u_wb_slave_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_sel_i(m_sel),
    .m_adr_i(m_adr), .m_dat_i(m_dat),
    .m_dat_o(m_dat_o), .m_ack_o(m_ack_o), .m_err_o(m_err_o),
    .s_cyc_o(s_cyc_o), .s_stb_o(s_stb_o), .s_we_o(s_we_o), .s_sel_o(s_sel_o),
    .s_adr_o(s_adr_o), .s_dat_o(s_dat_o), .s_dat_i(s_dat_i), .s_ack_i(s_ack_i)
  );

  // Configuration as given in the requirements.
  logic [AW-1:0] cfg_base  [NS] = '{24'h000000, 24'h200000, 24'h200000, 24'hE00000};
  int            cfg_shift [NS] = '{2, 1, 0, 0};
  int            cfg_aw    [NS] = '{12, 10, 8, 16};

  int n_chk = 0, n_fail = 0;
  bit err_model = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_sel();
    if (!(m_cyc && m_stb)) return -1;
    for (int i = 0; i < NS; i++)
      if (m_adr[23:21] == cfg_base[i][23:21]) return i;
    return -1;
  endfunction

  task automatic check_all();
    int s;
    logic [NS-1:0] exp_cyc;
    s = model_sel();
    exp_cyc = (s < 0) ? '0 : (NS'(1) << s);
    chk("R2/R3 s_cyc", 64'(s_cyc_o), 64'(exp_cyc));
    chk("R2 s_stb", 64'(s_stb_o), 64'(exp_cyc));
    chk("R5 m_ack", 64'(m_ack_o), 64'((s < 0) ? 1'b0 : s_ack_i[s]));
    chk("R5 m_dat", 64'(m_dat_o), 64'((s < 0) ? 32'h0 : s_dat_i[s*DW +: DW]));
    chk("R4 we/sel/dat", {27'h0, s_we_o, s_sel_o, s_dat_o}, {27'h0, m_we, m_sel, m_dat});
    chk("R9 m_err", 64'(m_err_o), 64'(err_model));
    for (int i = 0; i < NS; i++) begin
      longint a;
      a = (longint'(m_adr) >> cfg_shift[i]) & ((longint'(1) << cfg_aw[i]) - 1);
      chk(i == 3 ? "R6 s_adr" : "R7/R8 s_adr", 64'(s_adr_o[i*AW +: AW]), 64'(a));
    end
  endtask

  // One bus cycle: drive at the falling edge, check, model the edge.
  task automatic cycle(input bit c, input bit st, input logic [AW-1:0] a);
    bit nxt;
    @(negedge clk);
    m_cyc = c; m_stb = st; m_adr = a;
    m_we = 1'($urandom); m_sel = 4'($urandom); m_dat = $urandom;
    s_ack_i = 4'($urandom);
    for (int i = 0; i < NS; i++) s_dat_i[i*DW +: DW] = $urandom;
    #1;
    check_all();
    nxt = err_model ? 1'b0 : ((c && st) && (model_sel() < 0));
    @(posedge clk);
    err_model = nxt;
  endtask

  initial begin
    rst_n = 1'b0;
    m_cyc = 0; m_stb = 0; m_we = 0; m_sel = 0; m_adr = 0; m_dat = 0;
    s_ack_i = 0; s_dat_i = 0;
    repeat (3) @(negedge clk);
    // R10: reset state, even with an unmatched request held
    m_cyc = 1; m_stb = 1; m_adr = 24'h400000;
    @(negedge clk); #1;
    chk("R10 err in reset", 64'(m_err_o), 64'(0));
    m_cyc = 0; m_stb = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 err after reset", 64'(m_err_o), 64'(0));

    // R1: each defined tag
    cycle(1, 1, 24'h012345);  // slave 0, word 32-bit
    cycle(1, 1, 24'h3FFFFF);  // R3: overlap, slave 1 wins over 2
    cycle(1, 1, 24'hE0ABCD);  // slave 3, byte mode (R6)
    cycle(1, 1, 24'hFFFFFF);  // R8: upper bits masked
    // R2: strobe without cycle, cycle without strobe
    cycle(0, 1, 24'h000010);
    cycle(1, 0, 24'h000010);
    // R9: miss with strobe held four cycles gives alternating pulses
    cycle(1, 1, 24'h400000);
    cycle(1, 1, 24'h400000);
    cycle(1, 1, 24'h600004);
    cycle(1, 1, 24'hA00000);
    cycle(0, 0, 24'h400000);
    cycle(0, 0, 24'h400000);
    // R9: idle on unmapped address -> no error
    cycle(1, 0, 24'hC00000);
    cycle(1, 0, 24'hC00000);
    // Mixed traffic
    for (int k = 0; k < 600; k++) begin
      cycle(($urandom % 4) != 0, ($urandom % 3) != 0, 24'($urandom));
    end
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule